// File: doc/BRIEF.md
# Start-Up Request-Rate Ramp Controller

This block sets how fast the secondary-side controller of an isolated converter may ask the primary for switching cycles while the converter starts. Before the link to the primary is established, and for the whole soft-start window after it, the block holds requests at a slow initial rate and selects the reduced current limit. Once the handshake-done input rises, it shortens the minimum request period by a fixed amount at a fixed tick interval. The request rate therefore climbs linearly until the period reaches its floor, which is the full request rate.

When the ramp ends, the block checks the conditioned feedback flags. If the output has risen above the auto-restart level and the feedback pin is not shorted, the block enters normal running: full rate, full current limit and feedback-short protection armed. Otherwise it raises a sticky auto-restart request. The request generator must then stop issuing cycles, and the request stays high until the handshake input drops. If the output reaches regulation during the ramp, the ramp ends at once, but only when quasi-resonant programming is already finished. Periods are counted in clock cycles. With a 10 MHz clock, the default start period of 100 gives 100 kHz.

Top module: `ssr_ramp_ctrl`

## Requirements
- R1: After reset, and while handshake-done is low, the period limit equals START_PERIOD (default 100), the reduced-current-limit select is 1, short protection is 0 and auto-restart request is 0.
- R2: Call the clock edge that first samples handshake-done high edge 0. The period limit stays at START_PERIOD through edge TICK_CYCLES-1. It then drops by STEP (default 6) at every TICK_CYCLES-th edge (default 8).
- R3: The period limit never leaves the range MIN_PERIOD..START_PERIOD (default 40..100). A step that would go below MIN_PERIOD lands on MIN_PERIOD. The ramp ends at the edge where the period reaches MIN_PERIOD, which is edge 80 with the defaults.
- R4: During the ramp the reduced-current-limit select stays 1 and short protection stays 0. The feedback-short flag has no effect on the outputs during the ramp.
- R5: If the ramp ends with the auto-restart-level flag at 1 and the short flag at 0, then from that edge: period limit MIN_PERIOD, reduced-current-limit select 0, short protection 1, auto-restart request 0.
- R6: If the auto-restart-level flag is 0 at the edge where the ramp ends, the auto-restart request is 1 from that edge. Short protection is 1 and the period limit is MIN_PERIOD.
- R7: If the short flag is 1 at the edge where the ramp ends, the auto-restart request is 1 from that edge.
- R8: If the regulation flag and the QR-done flag are both 1 during the ramp (edge 1 onward), the next edge gives period limit MIN_PERIOD and the running outputs of R5.
- R9: The regulation flag with QR-done at 0 does not end the ramp, and the period keeps following R2.
- R10: While running, a short flag of 1 sets the auto-restart request at the next edge.
- R11: The auto-restart request stays 1 while handshake-done stays 1. Handshake-done at 0, in any phase, restores the R1 outputs at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hs_done_i | input | 1 | Handshake with primary complete |
| in_reg_i | input | 1 | Output voltage in regulation |
| fb_ar_ok_i | input | 1 | Feedback above auto-restart level |
| fb_short_i | input | 1 | Feedback below short threshold |
| qr_done_i | input | 1 | Quasi-resonant detection programming finished |
| req_period_o | output | PER_W | Minimum request period in clock cycles |
| ilim_low_o | output | 1 | Select reduced (75 %) current limit |
| short_prot_en_o | output | 1 | Feedback-short protection armed |
| ar_req_o | output | 1 | Auto-restart request (stop requesting cycles) |

## Verification
The assertions assume that every flag input is synchronous to `clk` and steady between edges. They also assume that handshake-done is the only input able to leave a fault. The regulation flag is assumed meaningful only once the ramp has begun. The bench changes inputs only on falling edges. It raises the regulation flag only from the second ramp cycle on, and it releases a fault only by dropping handshake-done. A fault that goes away on its own in the flags therefore never has to be modelled.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_RAMP  = 2'd1,
      PH_RUN   = 2'd2,
      PH_FAULT = 2'd3
   } ssr_phase_e;
endpackage

// File: rtl/ssr_tick_gen.sv
module ssr_tick_gen #(
   parameter int TICK_CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   output logic tick_o
);
   localparam int CW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
   localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

   initial begin
      if (TICK_CYCLES < 2) $error("ssr_tick_gen: TICK_CYCLES must be at least 2");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n || !en_i) cnt_q <= '0;
      else if (cnt_q == LAST) cnt_q <= '0;
      else cnt_q <= cnt_q + 1'b1;
   end

   assign tick_o = en_i && (cnt_q == LAST);

   // Ticks are spaced: no tick directly after a tick (R2)
   p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |=> !tick_o);
endmodule

// File: rtl/ssr_period_stepper.sv
module ssr_period_stepper #(
   parameter int PER_W        = 16,
   parameter int START_PERIOD = 100,
   parameter int MIN_PERIOD   = 40,
   parameter int STEP         = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_start_i,
   input  logic             jump_min_i,
   input  logic             tick_i,
   output logic [PER_W-1:0] period_o,
   output logic             last_step_o
);
   localparam logic [PER_W-1:0] P_START = PER_W'(START_PERIOD);
   localparam logic [PER_W-1:0] P_MIN   = PER_W'(MIN_PERIOD);
   localparam logic [PER_W-1:0] P_STEP  = PER_W'(STEP);
   localparam logic [PER_W-1:0] P_EDGE  = PER_W'(MIN_PERIOD + STEP);
   localparam bit EXACT = ((START_PERIOD - MIN_PERIOD) % STEP) == 0;

   initial begin
      if (STEP < 1) $error("ssr_period_stepper: STEP must be positive");
      if (MIN_PERIOD < 1 || START_PERIOD <= MIN_PERIOD)
         $error("ssr_period_stepper: need 0 < MIN_PERIOD < START_PERIOD");
      if (START_PERIOD >= (1 << PER_W))
         $error("ssr_period_stepper: START_PERIOD does not fit PER_W");
   end

   logic [PER_W-1:0] period_q;
   logic             at_last;

   generate
      if (EXACT) begin : g_exact
         // The span is a whole number of steps: the last step lands exactly.
         assign at_last = (period_q == P_EDGE);
      end else begin : g_clamp
         // The span is not a whole number of steps: the last step clamps.
         assign at_last = (period_q <= P_EDGE);
      end
   endgenerate

   assign last_step_o = tick_i && at_last;

   always_ff @(posedge clk) begin
      if (!rst_n || load_start_i) period_q <= P_START;
      else if (jump_min_i)        period_q <= P_MIN;
      else if (last_step_o)       period_q <= P_MIN;
      else if (tick_i)            period_q <= period_q - P_STEP;
   end

   assign period_o = period_q;

   p_period_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (period_o >= P_MIN) && (period_o <= P_START));

   p_step_size_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_start_i && !jump_min_i) |=>
         (period_o <= $past(period_o)) && (($past(period_o) - period_o) <= P_STEP));
endmodule

// File: rtl/ssr_phase_fsm.sv
module ssr_phase_fsm
   import ssr_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       hs_done_i,
   input  logic       in_reg_i,
   input  logic       qr_done_i,
   input  logic       fb_ar_ok_i,
   input  logic       fb_short_i,
   input  logic       last_step_i,
   output ssr_phase_e phase_o,
   output logic       abort_o
);
   ssr_phase_e phase_q, phase_d;

   assign abort_o = (phase_q == PH_RAMP) && hs_done_i && in_reg_i && qr_done_i;

   always_comb begin
      phase_d = phase_q;
      if (!hs_done_i) phase_d = PH_IDLE;
      else begin
         unique case (phase_q)
            PH_IDLE:  phase_d = PH_RAMP;
            PH_RAMP: begin
               if (abort_o) phase_d = PH_RUN;
               else if (last_step_i)
                  phase_d = (fb_ar_ok_i && !fb_short_i) ? PH_RUN : PH_FAULT;
            end
            PH_RUN:   if (fb_short_i) phase_d = PH_FAULT;
            PH_FAULT: phase_d = PH_FAULT;
            default:  phase_d = PH_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) phase_q <= PH_IDLE;
      else        phase_q <= phase_d;
   end

   assign phase_o = phase_q;

   p_fault_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_FAULT && hs_done_i) |=> (phase_q == PH_FAULT));

   p_qr_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_RAMP && hs_done_i && !qr_done_i && !last_step_i) |=>
         (phase_q == PH_RAMP));

   p_hs_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !hs_done_i |=> (phase_q == PH_IDLE));
endmodule

// File: rtl/ssr_ramp_ctrl.sv
module ssr_ramp_ctrl
   import ssr_pkg::*;
#(
   parameter int PER_W        = 16,
   parameter int START_PERIOD = 100,
   parameter int MIN_PERIOD   = 40,
   parameter int STEP         = 6,
   parameter int TICK_CYCLES  = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hs_done_i,
   input  logic             in_reg_i,
   input  logic             fb_ar_ok_i,
   input  logic             fb_short_i,
   input  logic             qr_done_i,
   output logic [PER_W-1:0] req_period_o,
   output logic             ilim_low_o,
   output logic             short_prot_en_o,
   output logic             ar_req_o
);
   localparam logic [PER_W-1:0] P_MIN = PER_W'(MIN_PERIOD);

   ssr_phase_e phase;
   logic       abort, tick, last_step, load_start;

   assign load_start = (phase == PH_IDLE) || !hs_done_i;

   ssr_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (phase == PH_RAMP),
      .tick_o (tick)
   );

   ssr_period_stepper #(
      .PER_W        (PER_W),
      .START_PERIOD (START_PERIOD),
      .MIN_PERIOD   (MIN_PERIOD),
      .STEP         (STEP)
   ) u_step (
      .clk          (clk),
      .rst_n        (rst_n),
      .load_start_i (load_start),
      .jump_min_i   (abort),
      .tick_i       (tick),
      .period_o     (req_period_o),
      .last_step_o  (last_step)
   );

   ssr_phase_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .hs_done_i   (hs_done_i),
      .in_reg_i    (in_reg_i),
      .qr_done_i   (qr_done_i),
      .fb_ar_ok_i  (fb_ar_ok_i),
      .fb_short_i  (fb_short_i),
      .last_step_i (last_step),
      .phase_o     (phase),
      .abort_o     (abort)
   );

   assign ilim_low_o      = (phase == PH_IDLE) || (phase == PH_RAMP);
   assign short_prot_en_o = (phase == PH_RUN)  || (phase == PH_FAULT);
   assign ar_req_o        = (phase == PH_FAULT);

   // Once protection is armed the stepper must be at full rate (R5)
   p_armed_full_rate_r5: assert property (@(posedge clk) disable iff (!rst_n)
      short_prot_en_o |-> (req_period_o == P_MIN));

   // Abort forces the floor period at the next edge (R8)
   p_abort_floor_r8: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> (req_period_o == P_MIN) && short_prot_en_o);

   // Short flag ignored while ramping: it alone never ends the ramp (R4)
   p_short_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_RAMP && hs_done_i && fb_short_i && !last_step && !abort)
         |=> !short_prot_en_o && !ar_req_o);
endmodule

// File: tb/tb_ssr_ramp_ctrl.sv
module tb_ssr_ramp_ctrl;
   localparam int CLK_P = 10;
   localparam int PW = 16, START = 100, MINP = 40, STEP = 6, TICK = 8;
   localparam int NT = ((START - MINP) / STEP) * TICK;

   logic clk = 0, rst_n = 0;
   logic hs = 0, inreg = 0, arok = 0, sh = 0, qr = 0;
   logic [PW-1:0] per;
   logic il, se, ar;

   int total = 0, bad = 0;
   bit finished = 0;

   logic [PW-1:0] q_per[$];
   logic          q_il[$], q_se[$], q_ar[$];
   string         q_tag[$];

   always #(CLK_P/2) clk = ~clk;

   ssr_ramp_ctrl #(.PER_W(PW), .START_PERIOD(START), .MIN_PERIOD(MINP),
                   .STEP(STEP), .TICK_CYCLES(TICK)) dut (
      .clk(clk), .rst_n(rst_n), .hs_done_i(hs), .in_reg_i(inreg),
      .fb_ar_ok_i(arok), .fb_short_i(sh), .qr_done_i(qr),
      .req_period_o(per), .ilim_low_o(il), .short_prot_en_o(se), .ar_req_o(ar));

   task automatic push(input int p, input bit i, input bit s, input bit a, input string t);
      q_per.push_back(PW'(p)); q_il.push_back(i); q_se.push_back(s);
      q_ar.push_back(a); q_tag.push_back(t);
   endtask

   task automatic drive(input bit h, input bit r, input bit ok, input bit s, input bit q);
      @(negedge clk);
      hs = h; inreg = r; arok = ok; sh = s; qr = q;
   endtask

   task automatic hold(input int n, input bit h, input bit s, input int p,
                       input bit i, input bit sn, input bit a, input string t);
      for (int k = 0; k < n; k++) begin
         drive(h, 0, 1, s, 1);
         push(p, i, sn, a, t);
      end
   endtask

   // One ramp from handshake; expected values follow R2..R9
   task automatic do_ramp(input int abort_at, input bit q, input int short_mid,
                          input bit ok_end, input bit short_end, input int drop_at);
      for (int i = 0; i <= NT; i++) begin
         bit r, s, ok;
         r  = (abort_at >= 1) && (i >= abort_at);
         s  = (i == short_mid) || ((i == NT) && short_end);
         ok = (i == NT) ? ok_end : 1'b0;
         if (i == drop_at) begin
            drive(0, r, ok, s, q);
            push(START, 1, 0, 0, "R11");
            return;
         end
         drive(1, r, ok, s, q);
         if (r && q) begin
            push(MINP, 0, 1, 0, "R8");
            return;
         end
         if (i < NT)
            push(START - STEP * (i / TICK), 1, 0, 0,
                 (i == short_mid) ? "R4" : (r ? "R9" : "R2"));
         else
            push(MINP, 0, 1, !ok_end || short_end,
                 short_end ? "R7" : (ok_end ? "R5" : "R6"));
      end
   endtask

   // Monitor: compare one expected item per clock, after outputs settle
   initial begin
      forever begin
         @(posedge clk); #1;
         if (q_per.size() > 0) begin
            logic [PW-1:0] ep; logic ei, es, ea; string et;
            ep = q_per.pop_front(); ei = q_il.pop_front(); es = q_se.pop_front();
            ea = q_ar.pop_front(); et = q_tag.pop_front();
            total++;
            if (per !== ep || il !== ei || se !== es || ar !== ea) begin
               bad++;
               $display("FAIL %s: per=%0d ilim=%0b sen=%0b ar=%0b expected per=%0d ilim=%0b sen=%0b ar=%0b",
                        et, per, il, se, ar, ep, ei, es, ea);
            end
         end
      end
   end

   initial begin
      #(CLK_P * 20000);
      if (!finished) begin
         bad++;
         $display("FAIL watchdog: run did not complete");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      hold(2, 0, 0, START, 1, 0, 0, "R1");
      // normal ramp: short pulse mid-ramp, regulation without QR-done
      do_ramp(30, 0, 20, 1, 0, -1);
      hold(3, 1, 0, MINP, 0, 1, 0, "R5");
      hold(1, 1, 1, MINP, 0, 1, 1, "R10");
      hold(2, 1, 0, MINP, 0, 1, 1, "R11");
      hold(2, 0, 0, START, 1, 0, 0, "R11");
      // output never rises above auto-restart level
      do_ramp(-1, 0, -1, 0, 0, -1);
      hold(2, 1, 0, MINP, 0, 1, 1, "R6");
      hold(1, 0, 0, START, 1, 0, 0, "R11");
      // feedback shorted at ramp end
      do_ramp(-1, 0, -1, 1, 1, -1);
      hold(2, 1, 0, MINP, 0, 1, 1, "R7");
      hold(1, 0, 0, START, 1, 0, 0, "R11");
      // early abort on regulation with QR programming done
      do_ramp(17, 1, -1, 1, 0, -1);
      hold(2, 1, 0, MINP, 0, 1, 0, "R8");
      hold(1, 0, 0, START, 1, 0, 0, "R11");
      // handshake lost mid-ramp, then a clean restart to check R3 floor
      do_ramp(-1, 0, -1, 1, 0, 25);
      hold(1, 0, 0, START, 1, 0, 0, "R1");
      do_ramp(-1, 0, -1, 1, 0, -1);
      hold(2, 1, 0, MINP, 0, 1, 0, "R3");
      repeat (3) @(posedge clk);
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule